// File: doc/BRIEF.md
# Tiled Five-Point Stencil Engine

This block advances one rectangular tile of a 2D grid through a fixed number of Jacobi-style time steps. At each step, every interior point is replaced by a scaled sum of itself and its four axis-aligned neighbours, taken from the previous step. A tile has `S1` rows and `S2` columns. It is surrounded by a one-cell ring of boundary cells, which is the reach of the five-point stencil. The host streams the whole `(S1+2) x (S2+2)` grid in through a valid/ready input and pulses `start`. The engine then sweeps the tile `S0` times and streams the final interior values out.

Inside the block, two local grid buffers alternate between source and destination. Values are 32-bit signed fixed point. Each point's sum of five is multiplied by a signed Q1.15 coefficient and saturated back to 32 bits. The datapath takes one group of `UF` adjacent points per cycle, and no cycle is spent on hazards.

Tiles at the domain edge are handled by the same engine through padding. `validRows`/`validCols` mark the real part of the tile. Padded points are computed but never written back and never emitted.

Top module: `stencil_tile_engine`

## Requirements
- R1: After reset, `inReady`, `outValid`, `busy` and `done` are all 0.
- R2: A `start` pulse while idle captures `validRows` and `validCols`, and the engine then accepts exactly `(S1+2)*(S2+2)` values in row-major order. Row 0 and row S1+1 form the boundary ring, as do column 0 and column S2+1. `inReady` stays high until the last value is taken, and gaps in `inValid` are allowed.
- R3: One step maps each real interior point to `sat32((C+N+S+W+E) * coef >>> 15)`. All five operands come from the previous step, `coef` is signed 16-bit, and the shift is arithmetic.
- R4: Exactly `S0` steps are applied before output. Boundary cells keep their loaded values for the whole tile.
- R5: The sweep issues one group of `UF` points per cycle with no stalls. The first output is valid exactly `S0*S1*(S2/UF)+4` cycles after the cycle that follows the last accepted input.
- R6: Row `r` (1..S1) and column `c` (1..S2) are real when `r <= validRows` and `c <= validCols`. Other interior points are never written back, so they keep their loaded values for their neighbours, and they are never emitted.
- R7: Real points leave in row-major order, one per handshake. While `outValid` is high and `outReady` is low, `outValid` and `outData` hold.
- R8: `done` is high for exactly one cycle, the cycle after the last output handshake. At that point `busy` is 0.
- R9: `start` is ignored while `busy` is high, and the captured extents do not change.
- R10: Results above `2^31-1` clamp to `2^31-1`, and results below `-2^31` clamp to `-2^31`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tile (taken only while idle) |
| coef | input | 16 | Signed Q1.15 update coefficient, held stable during a tile |
| validRows | input | $clog2(S1+1) | Number of real rows, 1..S1 |
| validCols | input | $clog2(S2+1) | Number of real columns, 1..S2 |
| inValid | input | 1 | Input value present |
| inData | input | 32 | Grid value, row-major, boundary ring included |
| inReady | output | 1 | Engine accepts input |
| outValid | output | 1 | Output value present |
| outData | output | 32 | Final value of a real interior point |
| outReady | input | 1 | Consumer accepts output |
| busy | output | 1 | Tile in progress |
| done | output | 1 | One-cycle end-of-tile pulse |

## Verification
The assertions take for granted that `coef` stays constant while `busy` is high. They also assume `validRows` and `validCols` lie in 1..S1 and 1..S2 when `start` is taken. The stencil timing assumes the size rules on `S1`, `S2` and `UF` hold, so that a step's writes land before the next step reads them. The stimulus changes `coef` and the extents only while the engine is idle, apart from one deliberate mid-tile `start` pulse that carries different extents. It also sweeps tiles with full, odd and partial extents, random and saturating data, input gaps and output backpressure.

// File: rtl/stencil_pkg.sv
package stencil_pkg;

  // Pipeline stages between issue and the result register; memory write is one edge later.
  localparam int PIPE_STAGES = 3;
  localparam int WB_LAT      = PIPE_STAGES + 1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_SWEEP,
    PH_DRAIN,
    PH_EMIT
  } phase_e;

  // Strobes from sequencing to datapath. Index fields are wide; the datapath narrows them.
  typedef struct packed {
    logic        loadWe;
    logic [15:0] loadIdx;
    logic        issue;
    logic        srcSel;
    logic [15:0] row;
    logic [15:0] grp;
    logic        outSel;
    logic [15:0] outIdx;
  } stencil_ctl_t;

endpackage

// File: rtl/stencil_ctrl.sv
module stencil_ctrl
  import stencil_pkg::*;
#(
  parameter int S0 = 3,
  parameter int S1 = 4,
  parameter int S2 = 8,
  parameter int UF = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [$clog2(S1+1)-1:0]    validRows,
  input  logic [$clog2(S2+1)-1:0]    validCols,
  input  logic                       inValid,
  output logic                       inReady,
  output logic                       outValid,
  input  logic                       outReady,
  output logic                       busy,
  output logic                       done,
  output stencil_ctl_t               ctl,
  output logic [UF-1:0]              laneMask
);

  localparam int GC   = S2 + 2;
  localparam int GRID = (S1 + 2) * GC;
  localparam int NG   = S2 / UF;
  localparam int LW   = $clog2(GRID);
  localparam int RW   = $clog2(S1 + 1);
  localparam int CW   = $clog2(S2 + 1);
  localparam int SW   = $clog2(S0 + 1);
  localparam int GW   = $clog2(NG + 1);
  localparam int DCW  = $clog2(WB_LAT + 1);

  localparam logic [LW-1:0]  LAST_LOAD  = LW'(GRID - 1);
  localparam logic [SW-1:0]  LAST_STEP  = SW'(S0 - 1);
  localparam logic [RW-1:0]  LAST_ROW   = RW'(S1);
  localparam logic [GW-1:0]  LAST_GRP   = GW'(NG - 1);
  localparam logic [DCW-1:0] LAST_DRAIN = DCW'(WB_LAT - 1);

  phase_e         phase;
  logic [LW-1:0]  loadIdx;
  logic [SW-1:0]  stepCnt;
  logic [RW-1:0]  rowCnt;
  logic [GW-1:0]  grpCnt;
  logic [DCW-1:0] drainCnt;
  logic [RW-1:0]  oRow;
  logic [CW-1:0]  oCol;
  logic [RW-1:0]  vrReg;
  logic [CW-1:0]  vcReg;

  assign inReady  = (phase == PH_LOAD);
  assign outValid = (phase == PH_EMIT);
  assign busy     = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      loadIdx  <= '0;
      stepCnt  <= '0;
      rowCnt   <= RW'(1);
      grpCnt   <= '0;
      drainCnt <= '0;
      oRow     <= RW'(1);
      oCol     <= CW'(1);
      vrReg    <= '0;
      vcReg    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_LOAD;
            loadIdx <= '0;
            vrReg   <= validRows;
            vcReg   <= validCols;
          end
        end
        PH_LOAD: begin
          if (inValid) begin
            if (loadIdx == LAST_LOAD) begin
              phase   <= PH_SWEEP;
              stepCnt <= '0;
              rowCnt  <= RW'(1);
              grpCnt  <= '0;
            end else begin
              loadIdx <= loadIdx + 1'b1;
            end
          end
        end
        PH_SWEEP: begin
          if (grpCnt == LAST_GRP) begin
            grpCnt <= '0;
            if (rowCnt == LAST_ROW) begin
              rowCnt <= RW'(1);
              if (stepCnt == LAST_STEP) begin
                phase    <= PH_DRAIN;
                drainCnt <= '0;
              end else begin
                stepCnt <= stepCnt + 1'b1;
              end
            end else begin
              rowCnt <= rowCnt + 1'b1;
            end
          end else begin
            grpCnt <= grpCnt + 1'b1;
          end
        end
        PH_DRAIN: begin
          if (drainCnt == LAST_DRAIN) begin
            phase <= PH_EMIT;
            oRow  <= RW'(1);
            oCol  <= CW'(1);
          end else begin
            drainCnt <= drainCnt + 1'b1;
          end
        end
        PH_EMIT: begin
          if (outReady) begin
            if (oCol == vcReg) begin
              oCol <= CW'(1);
              if (oRow == vrReg) begin
                phase <= PH_IDLE;
                done  <= 1'b1;
              end else begin
                oRow <= oRow + 1'b1;
              end
            end else begin
              oCol <= oCol + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.loadWe  = inValid && inReady;
    ctl.loadIdx = 16'(loadIdx);
    ctl.issue   = (phase == PH_SWEEP);
    ctl.srcSel  = stepCnt[0];
    ctl.row     = 16'(rowCnt);
    ctl.grp     = 16'(grpCnt);
    ctl.outSel  = (S0 % 2) != 0;
    ctl.outIdx  = 16'(int'(oRow) * GC + int'(oCol));
  end

  // Lane validity for padded (dummy) iterations at the tile edge.
  for (genvar l = 0; l < UF; l++) begin : g_mask
    assign laneMask[l] = (rowCnt <= vrReg) &&
                         ((int'(grpCnt) * UF + l + 1) <= int'(vcReg));
  end

  a_r8_done_single : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r7_hold_valid : assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
  a_r2_wait_for_input : assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> inReady);
  a_r9_busy_start : assert property (@(posedge clk) disable iff (!rstN)
    (start && inReady) |=> (inReady || ctl.issue));

endmodule

// File: rtl/stencil_dpath.sv
module stencil_dpath
  import stencil_pkg::*;
#(
  parameter int S1 = 4,
  parameter int S2 = 8,
  parameter int UF = 2,
  parameter int DW = 32,
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [FW-1:0] coef,
  input  stencil_ctl_t         ctl,
  input  logic [UF-1:0]        laneMask,
  input  logic [DW-1:0]        inData,
  output logic [DW-1:0]        outData
);

  localparam int GC   = S2 + 2;
  localparam int GRID = (S1 + 2) * GC;
  localparam int AW   = $clog2(GRID);
  localparam int SUMW = DW + 3;
  localparam int PW   = SUMW + FW;

  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAXD = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIND = {1'b1, {(DW-1){1'b0}}};

  typedef logic [AW-1:0] addr_t;

  logic signed [DW-1:0] bank0   [GRID];
  logic signed [DW-1:0] bank1   [GRID];
  logic signed [DW-1:0] srcBank [GRID];

  addr_t                  laneAddr [UF];
  logic signed [SUMW-1:0] laneSum  [UF];
  logic [DW-1:0]          satRes   [UF];

  logic                   s1Valid, s2Valid, s3Valid;
  logic                   s1Dst, s2Dst, s3Dst;
  logic [UF-1:0]          s1Mask, s2Mask, s3Mask;
  addr_t                  s1Addr [UF];
  addr_t                  s2Addr [UF];
  addr_t                  s3Addr [UF];
  logic signed [SUMW-1:0] s1Sum  [UF];
  logic signed [PW-1:0]   s2Prod [UF];
  logic [DW-1:0]          s3Res  [UF];

  always_comb begin
    for (int i = 0; i < GRID; i++) begin
      srcBank[i] = ctl.srcSel ? bank1[i] : bank0[i];
    end
  end

  // Stencil gather: centre plus four neighbours per lane.
  for (genvar l = 0; l < UF; l++) begin : g_lane
    always_comb begin
      int r;
      int c;
      r = int'(ctl.row);
      c = int'(ctl.grp) * UF + l + 1;
      laneAddr[l] = addr_t'(r * GC + c);
      laneSum[l]  = SUMW'(srcBank[addr_t'(r * GC + c)])
                  + SUMW'(srcBank[addr_t'((r - 1) * GC + c)])
                  + SUMW'(srcBank[addr_t'((r + 1) * GC + c)])
                  + SUMW'(srcBank[addr_t'(r * GC + c - 1)])
                  + SUMW'(srcBank[addr_t'(r * GC + c + 1)]);
    end

    always_comb begin
      logic signed [PW-1:0] shifted;
      shifted = s2Prod[l] >>> (FW - 1);
      if (shifted > MAXV)      satRes[l] = MAXD;
      else if (shifted < MINV) satRes[l] = MIND;
      else                     satRes[l] = DW'(shifted);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
      s3Valid <= 1'b0;
    end else begin
      s1Valid <= ctl.issue;
      s2Valid <= s1Valid;
      s3Valid <= s2Valid;
    end
  end

  always_ff @(posedge clk) begin
    s1Dst  <= !ctl.srcSel;
    s2Dst  <= s1Dst;
    s3Dst  <= s2Dst;
    s1Mask <= laneMask;
    s2Mask <= s1Mask;
    s3Mask <= s2Mask;
    for (int l = 0; l < UF; l++) begin
      s1Addr[l] <= laneAddr[l];
      s2Addr[l] <= s1Addr[l];
      s3Addr[l] <= s2Addr[l];
      s1Sum[l]  <= laneSum[l];
      s2Prod[l] <= PW'(s1Sum[l]) * PW'(coef);
      s3Res[l]  <= satRes[l];
    end
  end

  // Buffer writes: loading fills both banks; write-back only for real lanes.
  always_ff @(posedge clk) begin
    if (ctl.loadWe) begin
      bank0[addr_t'(ctl.loadIdx)] <= inData;
      bank1[addr_t'(ctl.loadIdx)] <= inData;
    end
    for (int l = 0; l < UF; l++) begin
      if (s3Valid && s3Mask[l]) begin
        if (s3Dst) bank1[s3Addr[l]] <= s3Res[l];
        else       bank0[s3Addr[l]] <= s3Res[l];
      end
    end
  end

  assign outData = ctl.outSel ? bank1[addr_t'(ctl.outIdx)] : bank0[addr_t'(ctl.outIdx)];

  a_r2_no_writeback_in_load : assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWe |-> !s3Valid);
  a_r5_writeback_lag : assert property (@(posedge clk) disable iff (!rstN)
    s3Valid |-> $past(ctl.issue, 3));

endmodule

// File: rtl/stencil_tile_engine.sv
module stencil_tile_engine
  import stencil_pkg::*;
#(
  parameter int S0 = 3,
  parameter int S1 = 4,
  parameter int S2 = 8,
  parameter int UF = 2,
  parameter int DW = 32,
  parameter int FW = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic signed [FW-1:0]    coef,
  input  logic [$clog2(S1+1)-1:0] validRows,
  input  logic [$clog2(S2+1)-1:0] validCols,
  input  logic                    inValid,
  input  logic [DW-1:0]           inData,
  output logic                    inReady,
  output logic                    outValid,
  output logic [DW-1:0]           outData,
  input  logic                    outReady,
  output logic                    busy,
  output logic                    done
);

  stencil_ctl_t  ctl;
  logic [UF-1:0] laneMask;

  stencil_ctrl #(.S0(S0), .S1(S1), .S2(S2), .UF(UF)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .validRows (validRows),
    .validCols (validCols),
    .inValid   (inValid),
    .inReady   (inReady),
    .outValid  (outValid),
    .outReady  (outReady),
    .busy      (busy),
    .done      (done),
    .ctl       (ctl),
    .laneMask  (laneMask)
  );

  stencil_dpath #(.S1(S1), .S2(S2), .UF(UF), .DW(DW), .FW(FW)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .coef     (coef),
    .ctl      (ctl),
    .laneMask (laneMask),
    .inData   (inData),
    .outData  (outData)
  );

  a_r7_data_stable : assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));
  a_r8_done_idle : assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: tb/stencil_tile_engine_tb.sv
module stencil_tile_engine_tb_top;

  localparam int S0 = 3;
  localparam int S1 = 4;
  localparam int S2 = 8;
  localparam int UF = 2;
  localparam int GR = S1 + 2;
  localparam int GC = S2 + 2;
  localparam int LAT = S0 * S1 * (S2 / UF) + 4;

  logic clk = 1'b0;
  logic rstN;
  logic start;
  logic signed [15:0] coef;
  logic [$clog2(S1+1)-1:0] validRows;
  logic [$clog2(S2+1)-1:0] validCols;
  logic inValid;
  logic [31:0] inData;
  logic inReady, outValid, outReady, busy, done;
  logic [31:0] outData;

  int testCnt = 0;
  int failCnt = 0;
  longint grid [GR][GC];
  longint expv [GR][GC];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  stencil_tile_engine #(.S0(S0), .S1(S1), .S2(S2), .UF(UF)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .coef(coef),
    .validRows(validRows), .validCols(validCols),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return longint'(signed'(seed)) >>> 11;
  endfunction

  function automatic longint sat32(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  task automatic model(input int vr, input int vc, input longint cf);
    longint cur [GR][GC];
    longint nxt [GR][GC];
    cur = grid;
    for (int t = 0; t < S0; t++) begin
      nxt = cur;
      for (int r = 1; r <= vr; r++)
        for (int c = 1; c <= vc; c++)
          nxt[r][c] = sat32(((cur[r][c] + cur[r-1][c] + cur[r+1][c] +
                              cur[r][c-1] + cur[r][c+1]) * cf) >>> 15);
      cur = nxt;
    end
    expv = cur;
  endtask

  // kind 0: random, 1: large positive, 2: large negative
  task automatic runTile(input int vr, input int vc, input int cf, input int kind,
                         input bit bp, input bit poke, input bit measure, input string tag);
    int lat;
    int k;
    int cyc;
    bit held;
    logic [31:0] heldData;
    for (int r = 0; r < GR; r++)
      for (int c = 0; c < GC; c++) begin
        if (kind == 0) grid[r][c] = nextRand();
        else if (kind == 1) grid[r][c] = 64'sd1879048192 + (nextRand() & 64'hFFFF);
        else grid[r][c] = -64'sd1879048192 - (nextRand() & 64'hFFFF);
      end
    model(vr, vc, longint'(cf));
    coef = 16'(cf);
    validRows = 3'(vr);
    validCols = 4'(vc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(inReady == 1'b1, "R2 inReady after start", longint'(inReady), 1);
    for (int i = 0; i < GR * GC; i++) begin
      if (kind == 0 && (i % 7) == 3) begin
        inValid = 1'b0;
        @(negedge clk);
        chk(inReady == 1'b1, "R2 inReady held during gap", longint'(inReady), 1);
      end
      inValid = 1'b1;
      inData = 32'(grid[i / GC][i % GC]);
      @(negedge clk);
    end
    inValid = 1'b0;
    chk(inReady == 1'b0, "R2 load ends after full grid", longint'(inReady), 0);
    lat = 0;
    while (!outValid) begin
      if (poke && lat == 10) begin
        start = 1'b1;
        validRows = 3'd1;
        validCols = 4'd1;
      end else begin
        start = 1'b0;
      end
      lat++;
      @(negedge clk);
    end
    start = 1'b0;
    if (measure) chk(lat == LAT, "R5 sweep latency", longint'(lat), longint'(LAT));
    k = 0;
    cyc = 0;
    held = 1'b0;
    heldData = '0;
    while (k < vr * vc) begin
      if (held) begin
        chk(outValid == 1'b1 && outData == heldData, {"R7 hold under backpressure ", tag},
            longint'(outData), longint'(heldData));
      end
      outReady = bp ? ((cyc % 3) != 0) : 1'b1;
      held = 1'b0;
      if (outValid && outReady) begin
        chk(longint'(signed'(outData)) == expv[k / vc + 1][k % vc + 1],
            {"R3/R4/R6/R10 value ", tag},
            longint'(signed'(outData)), expv[k / vc + 1][k % vc + 1]);
        k++;
      end else if (outValid) begin
        held = 1'b1;
        heldData = outData;
      end
      cyc++;
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(done == 1'b1, {"R8 done after last beat ", tag}, longint'(done), 1);
    chk(outValid == 1'b0, {"R6 no extra output ", tag}, longint'(outValid), 0);
    chk(busy == 1'b0, {"R8 idle with done ", tag}, longint'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, {"R8 done single cycle ", tag}, longint'(done), 0);
    if (poke) chk(inReady == 1'b0 && busy == 1'b0, "R9 start while busy ignored",
                  longint'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    start = 1'b0;
    coef = '0;
    validRows = '0;
    validCols = '0;
    inValid = 1'b0;
    inData = '0;
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    chk(inReady == 1'b0, "R1 inReady reset", longint'(inReady), 0);
    chk(outValid == 1'b0, "R1 outValid reset", longint'(outValid), 0);
    chk(busy == 1'b0, "R1 busy reset", longint'(busy), 0);
    chk(done == 1'b0, "R1 done reset", longint'(done), 0);
    rstN = 1'b1;
    @(negedge clk);

    runTile(4, 8, 13107, 0, 1'b0, 1'b0, 1'b1, "full");
    runTile(3, 5, -8000, 0, 1'b1, 1'b1, 1'b1, "padded");
    runTile(2, 7, 20000, 0, 1'b1, 1'b0, 1'b0, "odd-cols");
    runTile(4, 8, 32767, 1, 1'b0, 1'b0, 1'b0, "R10 sat-high");
    runTile(1, 2, 32767, 2, 1'b1, 1'b0, 1'b0, "R10 sat-low");
    runTile(4, 1, -32768, 0, 1'b0, 1'b0, 1'b1, "one-col");

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule